// File: doc/BRIEF.md
# Programmable Burst Preamble Detector

This block sits behind the clock-recovery front end of a burst-mode receiver. It watches the recovered bit stream, which arrives one bit per cycle whenever the valid strobe is high. It reports when a programmed preamble has gone by. Two reference words are compared against the most recent bits at the same time. Only the newest `length` bits take part, and `length` can be set from 1 to 32.

A second, independent detector counts toggling bits. It flags once `length` consecutive alternating bits have arrived. Both detectors restart after every flag, so a preamble longer than the match length produces a flag for each further full window. A saturating counter reports how many pattern windows in a row have matched. Configuration uses a small write port: address 0 holds the length, and addresses 1 and 2 hold the two patterns.

Top module: `burst_preamble_detector`

## Requirements
- R1: After reset all outputs are 0. The length is 32. Pattern 0 is 0x5555_5555 and pattern 1 is 0xAAAA_AAAA.
- R2: Bit k of the compare window is the bit received k valid bits ago, so bit 0 is the newest. Only the low `length` bits of the window and of each pattern are compared.
- R3: Both patterns are checked in the same cycle. `det_pat` gives the index of the matching pattern. When both match, it gives 0. It is 0 whenever `det_pulse` is low.
- R4: A match is only evaluated once `length` valid bits have arrived since the last clear or the last hit. A long repeating preamble therefore produces one pulse per `length` bits.
- R5: `run_cnt` goes up by one on each hit and saturates at all ones. It goes back to 0 when a full window is evaluated and matches neither pattern.
- R6: `alt_pulse` fires when the current alternating run reaches `length` bits. After a flag the run starts again from zero. Two equal adjacent bits restart the run, and the second of the pair counts as its first bit.
- R7: A cycle with `bit_valid` low changes no state. Both pulses are low after that cycle.
- R8: A write to address 0 sets the length from `cfg_wdata[5:0]`. A value of 0 or above 32 selects 32. Writes to addresses 1 and 2 set patterns 0 and 1. A write to address 3 has no effect.
- R9: A write to addresses 0 to 2 clears the history, the window fill, the alternating run and `run_cnt`. A bit offered in the same cycle is discarded.
- R10: The pulses and `run_cnt` are registered. They reflect the bit presented in the previous cycle, and each pulse lasts one cycle per qualifying bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a new bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 length, 1 pattern 0, 2 pattern 1 |
| cfg_wdata | input | 32 | Write data |
| det_pulse | output | 1 | One-cycle pattern match pulse |
| det_pat | output | 1 | Index of the matching pattern |
| alt_pulse | output | 1 | One-cycle alternating-run pulse |
| run_cnt | output | 8 | Count of back-to-back matching windows |

## Verification
The hardest state to reach is saturation of `run_cnt`. It needs 255 matching windows with no failed window in between. The bench gets there by setting the length to 1 with pattern 0 equal to 1, then streaming ones, so that every bit is a full matching window. The configuration-write-versus-bit collision, masked upper pattern bits and a pseudo-random stream with random valid gaps are also driven. Every result is compared against a bench-side model built from the requirements.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
   localparam int BPD_REG_LEN      = 0;
   localparam int BPD_REG_PAT_BASE = 1;

   function automatic int bpd_addr_w(input int num_pat);
      int w;
      w = $clog2(num_pat + 1);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int bpd_id_w(input int num_pat);
      return (num_pat > 1) ? $clog2(num_pat) : 1;
   endfunction
endpackage

// File: rtl/bpd_cfg_regs.sv
module bpd_cfg_regs #(
   parameter int MAX_LEN = 32,
   parameter int NUM_PAT = 2,
   parameter int LEN_W   = 6,
   parameter int AW      = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [AW-1:0]                    addr,
   input  logic [MAX_LEN-1:0]               wdata,
   output logic [LEN_W-1:0]                 len,
   output logic [NUM_PAT-1:0][MAX_LEN-1:0]  pats,
   output logic                             clr
);
   localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);

   function automatic logic [MAX_LEN-1:0] alt_word(input logic lsb);
      logic [MAX_LEN-1:0] w;
      for (int k = 0; k < MAX_LEN; k++) w[k] = lsb ^ k[0];
      return w;
   endfunction

   logic [LEN_W-1:0] wlen;
   assign wlen = wdata[LEN_W-1:0];
   assign clr  = we && (int'(addr) <= NUM_PAT);

   always_ff @(posedge clk) begin
      if (!rst_n)
         len <= MAXL;
      else if (we && int'(addr) == bpd_pkg::BPD_REG_LEN)
         len <= (wlen == '0 || wlen > MAXL) ? MAXL : wlen;
   end

   for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
      logic [MAX_LEN-1:0] pat_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pat_q <= alt_word((i % 2) == 0);
         else if (we && int'(addr) == bpd_pkg::BPD_REG_PAT_BASE + i)
            pat_q <= wdata;
      end
      assign pats[i] = pat_q;
   end
endmodule

// File: rtl/bpd_window.sv
module bpd_window #(
   parameter int MAX_LEN = 32,
   parameter int NUM_PAT = 2,
   parameter int LEN_W   = 6,
   parameter int ID_W    = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             shift,
   input  logic                             bit_in,
   input  logic [LEN_W-1:0]                 len,
   input  logic [NUM_PAT-1:0][MAX_LEN-1:0]  pats,
   output logic                             hit,
   output logic [ID_W-1:0]                  hit_id,
   output logic                             miss
);
   localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);

   logic [MAX_LEN-1:0] hist_q, hist_n, mask;
   logic [LEN_W-1:0]   fill_q, fill_n;
   logic [NUM_PAT-1:0] eq;
   logic               full;

   assign hist_n = {hist_q[MAX_LEN-2:0], bit_in};
   assign fill_n = (fill_q == MAXL) ? MAXL : fill_q + 1'b1;
   assign full   = fill_n >= len;

   always_comb begin
      for (int k = 0; k < MAX_LEN; k++) mask[k] = (k < int'(len));
   end

   for (genvar i = 0; i < NUM_PAT; i++) begin : g_cmp
      assign eq[i] = ((hist_n ^ pats[i]) & mask) == '0;
   end

   always_comb begin
      hit_id = '0;
      for (int i = NUM_PAT - 1; i >= 0; i--) begin
         if (eq[i]) hit_id = ID_W'(i);
      end
   end

   assign hit  = shift && full && (|eq);
   assign miss = shift && full && !(|eq);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (shift) begin
         hist_q <= hist_n;
         fill_q <= hit ? '0 : fill_n;
      end
   end
endmodule

// File: rtl/bpd_alt_run.sv
module bpd_alt_run #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             bit_in,
   input  logic [LEN_W-1:0] len,
   output logic             flag
);
   logic [LEN_W-1:0] cnt_q, cnt_n;
   logic             prev_q;

   assign cnt_n = (cnt_q == '0 || bit_in != prev_q) ? cnt_q + 1'b1 : LEN_W'(1);
   assign flag  = shift && (cnt_n == len);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
      end else if (shift) begin
         cnt_q  <= flag ? '0 : cnt_n;
         prev_q <= bit_in;
      end
   end
endmodule

// File: rtl/burst_preamble_detector.sv
module burst_preamble_detector
   import bpd_pkg::*;
#(
   parameter int  MAX_LEN = 32,
   parameter int  NUM_PAT = 2,
   parameter int  CNT_W   = 8,
   localparam int LEN_W   = $clog2(MAX_LEN + 1),
   localparam int AW      = bpd_addr_w(NUM_PAT),
   localparam int ID_W    = bpd_id_w(NUM_PAT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_valid,
   input  logic               bit_in,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [MAX_LEN-1:0] cfg_wdata,
   output logic               det_pulse,
   output logic [ID_W-1:0]    det_pat,
   output logic               alt_pulse,
   output logic [CNT_W-1:0]   run_cnt
);
   if (MAX_LEN < 2 || MAX_LEN > 32) begin : g_bad_len
      $error("MAX_LEN must lie in 2..32");
   end
   if (NUM_PAT < 1 || NUM_PAT > 4) begin : g_bad_pat
      $error("NUM_PAT must lie in 1..4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [LEN_W-1:0]                len;
   logic [NUM_PAT-1:0][MAX_LEN-1:0] pats;
   logic                            clr, shift, hit, miss, alt_flag;
   logic [ID_W-1:0]                 hit_id;

   assign shift = bit_valid && !clr;

   bpd_cfg_regs #(.MAX_LEN(MAX_LEN), .NUM_PAT(NUM_PAT), .LEN_W(LEN_W), .AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .len(len), .pats(pats), .clr(clr));

   bpd_window #(.MAX_LEN(MAX_LEN), .NUM_PAT(NUM_PAT), .LEN_W(LEN_W), .ID_W(ID_W)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift), .bit_in(bit_in),
      .len(len), .pats(pats), .hit(hit), .hit_id(hit_id), .miss(miss));

   bpd_alt_run #(.LEN_W(LEN_W)) u_alt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift), .bit_in(bit_in),
      .len(len), .flag(alt_flag));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         det_pulse <= 1'b0;
         det_pat   <= '0;
         alt_pulse <= 1'b0;
         run_cnt   <= '0;
      end else begin
         det_pulse <= hit;
         det_pat   <= hit ? hit_id : '0;
         alt_pulse <= alt_flag;
         if (hit)
            run_cnt <= (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + 1'b1;
         else if (miss)
            run_cnt <= '0;
      end
   end
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
   parameter int NUM_PAT = 2,
   parameter int CNT_W   = 8,
   parameter int AW      = 2,
   parameter int ID_W    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_valid,
   input logic             cfg_we,
   input logic [AW-1:0]    cfg_addr,
   input logic             det_pulse,
   input logic [ID_W-1:0]  det_pat,
   input logic             alt_pulse,
   input logic [CNT_W-1:0] run_cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   p_det_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      det_pulse |-> $past(bit_valid));

   p_alt_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alt_pulse |-> $past(bit_valid));

   p_cnt_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bit_valid) && !$past(cfg_we)) |-> $stable(run_cnt));

   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      det_pulse |-> (run_cnt == CNT_W'($past(run_cnt) + 1'b1)) ||
                    (run_cnt == CMAX && $past(run_cnt) == CMAX));

   p_pat_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !det_pulse |-> det_pat == '0);

   p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we && (int'(cfg_addr) <= NUM_PAT)) |->
         (run_cnt == '0 && !det_pulse && !alt_pulse));
endmodule

bind burst_preamble_detector bpd_checker #(
   .NUM_PAT(NUM_PAT), .CNT_W(CNT_W), .AW(AW), .ID_W(ID_W)
) u_bpd_chk (
   .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .cfg_we(cfg_we),
   .cfg_addr(cfg_addr), .det_pulse(det_pulse), .det_pat(det_pat),
   .alt_pulse(alt_pulse), .run_cnt(run_cnt));

// File: tb/burst_preamble_detector_bench.sv
module burst_preamble_detector_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        det_pulse;
   logic [0:0]  det_pat;
   logic        alt_pulse;
   logic [7:0]  run_cnt;

   always #2 clk = ~clk;

   burst_preamble_detector u_burst_preamble_detector (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .det_pulse(det_pulse), .det_pat(det_pat), .alt_pulse(alt_pulse),
      .run_cnt(run_cnt));

   typedef struct {
      logic       det;
      logic       id;
      logic       alt;
      logic [7:0] cnt;
      string      tag;
   } exp_t;

   exp_t  q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   string cur_tag = "R1";

   // requirement model state
   logic [31:0] m_hist;
   logic [31:0] m_pat0, m_pat1;
   int          m_len, m_fill, m_alt, m_cnt;
   logic        m_prev;

   task automatic model_clear();
      m_hist = '0; m_fill = 0; m_alt = 0; m_prev = 1'b0; m_cnt = 0;
   endtask

   task automatic model_bit(input logic b, output exp_t e);
      logic [31:0] mask;
      logic        h0, h1;
      int          n;
      e.det = 1'b0; e.id = 1'b0; e.alt = 1'b0;
      m_hist = {m_hist[30:0], b};
      if (m_fill < 32) m_fill++;
      mask = (m_len == 32) ? 32'hFFFF_FFFF : ((32'h1 << m_len) - 1);
      if (m_fill >= m_len) begin
         h0 = ((m_hist ^ m_pat0) & mask) == 0;
         h1 = ((m_hist ^ m_pat1) & mask) == 0;
         if (h0 || h1) begin
            e.det = 1'b1; e.id = h0 ? 1'b0 : 1'b1; m_fill = 0;
            if (m_cnt != 255) m_cnt++;
         end else begin
            m_cnt = 0;
         end
      end
      n = (m_alt == 0 || b != m_prev) ? m_alt + 1 : 1;
      if (n == m_len) begin e.alt = 1'b1; m_alt = 0; end
      else m_alt = n;
      m_prev = b;
      e.cnt = 8'(m_cnt);
   endtask

   task automatic step(input logic v, input logic b);
      exp_t e;
      @(negedge clk);
      bit_valid = v; bit_in = b; cfg_we = 1'b0;
      if (v) model_bit(b, e);
      else begin e.det = 0; e.id = 0; e.alt = 0; e.cnt = 8'(m_cnt); end
      e.tag = cur_tag;
      q.push_back(e);
      @(posedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic v, input logic b);
      exp_t e;
      logic [5:0] l;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; bit_valid = v; bit_in = b;
      if (a <= 2) begin
         if (a == 0) begin
            l = d[5:0];
            m_len = (l == 0 || l > 32) ? 32 : int'(l);
         end else if (a == 1) m_pat0 = d;
         else m_pat1 = d;
         model_clear();
         e.det = 0; e.id = 0; e.alt = 0; e.cnt = 0;
      end else if (v) model_bit(b, e);
      else begin e.det = 0; e.id = 0; e.alt = 0; e.cnt = 8'(m_cnt); end
      e.tag = cur_tag;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0; bit_valid = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) step(1'b1, w[i]);
   endtask

   always begin
      exp_t e;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_chk++;
         if (det_pulse !== e.det || det_pat[0] !== e.id || alt_pulse !== e.alt || run_cnt !== e.cnt) begin
            n_bad++;
            $display("FAIL %s: got det=%0b pat=%0b alt=%0b cnt=%0d expected det=%0b pat=%0b alt=%0b cnt=%0d",
                     e.tag, det_pulse, det_pat, alt_pulse, run_cnt, e.det, e.id, e.alt, e.cnt);
         end
      end
   end

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      m_len = 32; m_pat0 = 32'h5555_5555; m_pat1 = 32'hAAAA_AAAA;
      model_clear();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      n_chk++;
      if (det_pulse !== 0 || det_pat !== 0 || alt_pulse !== 0 || run_cnt !== 0) begin
         n_bad++;
         $display("FAIL R1: got det=%0b pat=%0b alt=%0b cnt=%0d expected all 0",
                  det_pulse, det_pat, alt_pulse, run_cnt);
      end
      // R1 default length and patterns: alternating preamble ending in 1
      cur_tag = "R1"; send_word(32'h5555_5555, 32);
      // R4 longer preamble re-flags each full window
      cur_tag = "R4"; send_word(32'h5555_5555, 32); send_word(32'h5555_5555, 16);
      // R6 alternating run with a break
      cur_tag = "R8"; wr(2'd0, 32'd8, 1'b0, 1'b0);
      cur_tag = "R6"; send_word(32'b0101_1010_1010, 12); send_word(32'hAAAA, 16);
      // R3 parallel patterns and priority
      cur_tag = "R3"; wr(2'd1, 32'h0F, 1'b0, 1'b0); wr(2'd2, 32'hF0, 1'b0, 1'b0);
      send_word(32'hF0, 8); send_word(32'h0F, 8);
      wr(2'd2, 32'h0F, 1'b0, 1'b0); send_word(32'h0F, 8);
      // R2 upper pattern bits masked, partial window does not match
      cur_tag = "R2"; wr(2'd1, 32'hABCD_EF0F, 1'b0, 1'b0); send_word(32'h0F, 8);
      wr(2'd2, 32'h0000_0003, 1'b0, 1'b0); send_word(32'h7F, 7);
      // R5 consecutive count and its clearing
      cur_tag = "R5"; wr(2'd0, 32'd4, 1'b0, 1'b0); wr(2'd1, 32'h6, 1'b0, 1'b0);
      send_word(32'h666, 12); send_word(32'h7, 4); send_word(32'h66, 8);
      // R7 idle cycles interleaved
      cur_tag = "R7";
      for (int i = 0; i < 12; i++) begin
         step(1'b0, 1'b1);
         step(1'b1, (32'h666 >> (11 - i)) & 1'b1);
      end
      // R8 length clamping and unmapped address
      cur_tag = "R8"; wr(2'd0, 32'd0, 1'b0, 1'b0); wr(2'd1, 32'hC3A5_0F96, 1'b0, 1'b0);
      send_word(32'hC3A5_0F96, 32);
      wr(2'd0, 32'd40, 1'b0, 1'b0); send_word(32'h0000_0F96, 31);
      wr(2'd0, 32'd32, 1'b0, 1'b0); send_word(32'hC3A5_0F96 >> 8, 24);
      wr(2'd3, 32'hFFFF_FFFF, 1'b1, 1'b1); send_word(32'h96, 7);
      // R9 mapped write collides with a bit
      cur_tag = "R9"; send_word(32'hC3A5_0F96 >> 16, 16);
      wr(2'd2, 32'h0, 1'b1, 1'b0); send_word(32'hC3A5_0F96, 32);
      // R10 single-cycle pulses at length 1
      cur_tag = "R10"; wr(2'd0, 32'd1, 1'b0, 1'b0);
      step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b1);
      // R5 saturation
      cur_tag = "R5"; wr(2'd1, 32'h1, 1'b0, 1'b0); wr(2'd2, 32'h1, 1'b0, 1'b0);
      for (int i = 0; i < 260; i++) step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      // R2 pseudo-random stream with gaps
      cur_tag = "R2"; wr(2'd0, 32'd5, 1'b0, 1'b0); wr(2'd1, 32'b10110, 1'b0, 1'b0);
      wr(2'd2, 32'b01001, 1'b0, 1'b0);
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[3] | lfsr[7], lfsr[0]);
      end
      step(1'b0, 1'b0);
      #3;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule